// File: doc/BRIEF.md
# Boost Converter Plant Model

This block is a fixed-point model of a boost DC-DC power stage that runs in real time beside a controller. Each model sample, it advances two state variables: the current in the inductor and the voltage on the output capacitor. The advance follows the piecewise-linear circuit equations selected by the power switch. While the switch conducts, the inductor sees the source minus its own resistive drop, and the capacitor feeds the load alone. While the switch is open, the diode conducts. The inductor then also sees the output voltage across it, and the inductor current flows into the capacitor node.

The block has two timing domains. Every clock edge, a two-stage register pipeline recomputes the switch-dependent terms from the current state. These terms are the resistive drop, the load current, the switch-node voltage and the diode current. The pipeline breaks the algebraic loops of the circuit. The two integrators update only on clock edges where `sample_en` is high. The time step over inductance and the time step over capacitance are each applied as an arithmetic right shift. The load is supplied as a conductance, so no divider is needed. The switch input passes through a synchronising flop into a two-state phase machine. In state PH_CHARGE the switch conducts. In state PH_DIODE it is open. Transition TURN_ON goes from PH_DIODE to PH_CHARGE when the synchronised switch reads 1. Transition TURN_OFF goes back when it reads 0.

All words are signed two's complement with FW fractional bits (default 32 bits with 16 fractional). Samples must be at least three clock edges apart so that the pipeline reflects the last state update.

Top module: `boost_plant`

## Requirements
- R1: A synchronous active-low reset clears the inductor current, the capacitor voltage, the load current, the phase (to PH_DIODE) and every pipeline register to zero at the next clock edge.
- R2: In PH_CHARGE (sw_in = 1), a sample sets iL += sat(vin − mul(iL, rser)) >>> shift_l and vC += sat(−mul(vC, gload)) >>> shift_c. Here mul(a,b) is the saturated product (a·b) >>> FW.
- R3: In PH_DIODE (sw_in = 0), a sample sets iL += sat(vin − mul(iL, rser) − vC) >>> shift_l and vC += sat(iL − mul(vC, gload)) >>> shift_c. Both updates use the values from before the sample.
- R4: On edges where sample_en is 0, i_ind and v_cap keep their values, however long sample_en stays low.
- R5: The phase equals sw_in as sampled two clock edges earlier. Suppose sw_in changes before edge 1. A sample taken at edge 4 or earlier still uses the previous switch state. A sample at edge 5 or later uses the new one.
- R6: An accumulator that would leave the signed DW-bit range clamps to the largest positive value (0x7FFFFFFF by default) or the most negative value (0x80000000). It never wraps. Intermediate sums and products clamp the same way.
- R7: The scaled increment is a floor arithmetic right shift, so a negative term smaller than one step still moves the accumulator by −1.
- R8: i_load equals mul(vC, gload), computed from the capacitor voltage and conductance of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_en | input | 1 | One-cycle pulse that advances both integrators |
| sw_in | input | 1 | Power switch control, 1 = conducting |
| vin | input | DW | DC source voltage, signed Q format |
| rser | input | DW | Inductor series resistance, signed Q format |
| gload | input | DW | Load conductance (1/R), signed Q format |
| shift_l | input | SHW | Right shift that realises T/L |
| shift_c | input | SHW | Right shift that realises T/C |
| i_ind | output | DW | Inductor current state |
| v_cap | output | DW | Capacitor (output) voltage state |
| i_load | output | DW | Load current |

## Verification
The load-sign and charging properties assume that the conductance and load current they read stay unchanged across the edges they span. The charging property also assumes the phase has stayed in PH_CHARGE for three edges before a sample, so that the pipeline holds fully settled terms. The wrap properties take nothing for granted about the inputs. The stimulus changes the switch, source and configuration only on falling edges. It spaces every sample at least four edges after such a change, except in the deliberate latency probes. It keeps the conductance non-negative, so the arithmetic the assertions reason about matches the settled recurrence the scoreboard predicts.

// File: rtl/boost_pkg.sv
package boost_pkg;

    // Conduction phase of the power switch.
    typedef enum logic {
        PH_DIODE  = 1'b0,   // switch open, diode carries the inductor current
        PH_CHARGE = 1'b1    // switch closed, inductor tied to ground
    } phase_t;

endpackage

// File: rtl/boost_sync.sv
module boost_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/boost_fxmul.sv
module boost_fxmul #(
    parameter int DW = 32,
    parameter int FW = 16
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] p
);

    localparam int PW = 2 * DW;
    localparam int HW = DW - FW + 1;
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] b_x;
    logic signed [PW-1:0] prod;
    logic        [HW-1:0] hi;
    logic                 ovf;
    logic                 fx_unused;

    assign a_x  = {{DW{a[DW-1]}}, a};
    assign b_x  = {{DW{b[DW-1]}}, b};
    assign prod = a_x * b_x;

    // Bits above the kept window must all equal the kept sign bit.
    assign hi  = prod[PW-1:DW+FW-1];
    assign ovf = !((&hi) || !(|hi));

    // Fraction bits below the result are dropped (floor).
    assign fx_unused = ^prod[FW-1:0];

    always_comb begin
        if (ovf) p = prod[PW-1] ? MINV : MAXV;
        else     p = prod[DW+FW-1:FW];
    end

endmodule

// File: rtl/boost_integ.sv
module boost_integ #(
    parameter int DW  = 32,
    parameter int SHW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] din,
    input  logic        [SHW-1:0] sh,
    output logic signed [DW-1:0] acc,
    output logic signed [DW-1:0] step
);

    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [DW:0]   sum;
    logic signed [DW-1:0] nxt;

    assign step = din >>> sh;
    assign sum  = {acc[DW-1], acc} + {step[DW-1], step};

    always_comb begin
        if (sum[DW] != sum[DW-1]) nxt = sum[DW] ? MINV : MAXV;
        else                      nxt = sum[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= nxt;
    end

endmodule

// File: rtl/boost_plant.sv
module boost_plant
    import boost_pkg::*;
#(
    parameter int DW  = 32,
    parameter int FW  = 16,
    parameter int SHW = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic                  sw_in,
    input  logic signed [DW-1:0]  vin,
    input  logic signed [DW-1:0]  rser,
    input  logic signed [DW-1:0]  gload,
    input  logic        [SHW-1:0] shift_l,
    input  logic        [SHW-1:0] shift_c,
    output logic signed [DW-1:0]  i_ind,
    output logic signed [DW-1:0]  v_cap,
    output logic signed [DW-1:0]  i_load
);

    localparam int SYNC_STAGES = 1;
    localparam int XW          = DW + 2;
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [XW-1:0] MAXX = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [XW-1:0] MINX = {3'b111, {(DW-1){1'b0}}};

    function automatic logic signed [DW-1:0] clamp(input logic signed [XW-1:0] x);
        if (x > MAXX)      return MAXV;
        else if (x < MINX) return MINV;
        else               return x[DW-1:0];
    endfunction

    // ---------------- switch entry and phase machine ----------------
    logic   sw_sync;
    phase_t phase_q;
    phase_t phase_d;

    boost_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sw_in),
        .q     (sw_sync)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_DIODE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        unique case (phase_q)
            PH_DIODE:  phase_d = sw_sync ? PH_CHARGE : PH_DIODE;   // TURN_ON
            PH_CHARGE: phase_d = sw_sync ? PH_CHARGE : PH_DIODE;   // TURN_OFF
        endcase
    end

    // Switch-dependent terms selected by the phase.
    logic signed [DW-1:0] v2_d;
    logic signed [DW-1:0] icr_d;

    always_comb begin
        unique case (phase_q)
            PH_CHARGE: begin
                v2_d  = '0;
                icr_d = '0;
            end
            PH_DIODE: begin
                v2_d  = v_cap;
                icr_d = i_ind;
            end
        endcase
    end

    // ---------------- loop-breaking pipeline, stage 1 ----------------
    logic signed [DW-1:0] vrl_d;
    logic signed [DW-1:0] iload_d;
    logic signed [DW-1:0] vrl_q;
    logic signed [DW-1:0] iload_q;
    logic signed [DW-1:0] v2_q;
    logic signed [DW-1:0] icr_q;

    boost_fxmul #(.DW(DW), .FW(FW)) u_mul_rl (
        .a (i_ind),
        .b (rser),
        .p (vrl_d)
    );

    boost_fxmul #(.DW(DW), .FW(FW)) u_mul_ld (
        .a (v_cap),
        .b (gload),
        .p (iload_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vrl_q   <= '0;
            iload_q <= '0;
            v2_q    <= '0;
            icr_q   <= '0;
        end else begin
            vrl_q   <= vrl_d;
            iload_q <= iload_d;
            v2_q    <= v2_d;
            icr_q   <= icr_d;
        end
    end

    // ---------------- loop-breaking pipeline, stage 2 ----------------
    logic signed [XW-1:0] vl_x;
    logic signed [XW-1:0] ic_x;
    logic signed [DW-1:0] vl_q;
    logic signed [DW-1:0] ic_q;

    assign vl_x = {{2{vin[DW-1]}}, vin} - {{2{vrl_q[DW-1]}}, vrl_q}
                - {{2{v2_q[DW-1]}}, v2_q};
    assign ic_x = {{2{icr_q[DW-1]}}, icr_q} - {{2{iload_q[DW-1]}}, iload_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= '0;
            ic_q <= '0;
        end else begin
            vl_q <= clamp(vl_x);
            ic_q <= clamp(ic_x);
        end
    end

    // ---------------- sample-rate integrators ----------------
    logic signed [DW-1:0] il_step;
    logic signed [DW-1:0] vc_step;

    boost_integ #(.DW(DW), .SHW(SHW)) u_int_l (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_en),
        .din   (vl_q),
        .sh    (shift_l),
        .acc   (i_ind),
        .step  (il_step)
    );

    boost_integ #(.DW(DW), .SHW(SHW)) u_int_c (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_en),
        .din   (ic_q),
        .sh    (shift_c),
        .acc   (v_cap),
        .step  (vc_step)
    );

    assign i_load = iload_q;

endmodule

// File: rtl/boost_plant_chk.sv
module boost_plant_chk #(
    parameter int DW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_en,
    input logic                 sw_in,
    input logic signed [DW-1:0] gload,
    input logic                 phase_bit,
    input logic signed [DW-1:0] i_ind,
    input logic signed [DW-1:0] v_cap,
    input logic signed [DW-1:0] i_load,
    input logic signed [DW-1:0] il_step,
    input logic signed [DW-1:0] vc_step
);

    logic [1:0] rcnt;
    logic [1:0] on_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            rcnt <= 2'd0;
        else if (rcnt != 2'd3) rcnt <= rcnt + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          on_cnt <= 2'd0;
        else if (!phase_bit)                 on_cnt <= 2'd0;
        else if (on_cnt != 2'd3)             on_cnt <= on_cnt + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (i_ind == '0 && v_cap == '0 && i_load == '0)); // R1

    AST_CHARGE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && phase_bit && on_cnt == 2'd3 && rcnt >= 2'd2
         && $stable(i_load) && i_load >= 0) |-> vc_step <= 0); // R2

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(i_ind) && $stable(v_cap))); // R4

    AST_PHASE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rcnt >= 2'd2) |-> (phase_bit == $past(sw_in, 2))); // R5

    AST_IL_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !i_ind[DW-1] && !il_step[DW-1]) |=> !i_ind[DW-1]); // R6

    AST_IL_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && i_ind[DW-1] && il_step[DW-1]) |=> i_ind[DW-1]); // R6

    AST_VC_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !v_cap[DW-1] && !vc_step[DW-1]) |=> !v_cap[DW-1]); // R6

    AST_VC_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && v_cap[DW-1] && vc_step[DW-1]) |=> v_cap[DW-1]); // R6

    AST_LOAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (rcnt >= 2'd2 && $past(v_cap) >= 0 && $past(gload) >= 0) |-> i_load >= 0); // R8

endmodule

bind boost_plant boost_plant_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .sw_in     (sw_in),
    .gload     (gload),
    .phase_bit (phase_q),
    .i_ind     (i_ind),
    .v_cap     (v_cap),
    .i_load    (i_load),
    .il_step   (il_step),
    .vc_step   (vc_step)
);

// File: tb/boost_plant_test.sv
module boost_plant_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 32;
    localparam int FW  = 16;
    localparam int SHW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic sw_in = 1'b0;
    logic signed [DW-1:0] vin = '0;
    logic signed [DW-1:0] rser = '0;
    logic signed [DW-1:0] gload = '0;
    logic [SHW-1:0] shift_l = '0;
    logic [SHW-1:0] shift_c = '0;
    logic signed [DW-1:0] i_ind;
    logic signed [DW-1:0] v_cap;
    logic signed [DW-1:0] i_load;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boost_plant #(.DW(DW), .FW(FW), .SHW(SHW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sw_in     (sw_in),
        .vin       (vin),
        .rser      (rser),
        .gload     (gload),
        .shift_l   (shift_l),
        .shift_c   (shift_c),
        .i_ind     (i_ind),
        .v_cap     (v_cap),
        .i_load    (i_load)
    );

    typedef struct {
        longint il;
        longint vc;
        longint ld;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    exp_t   cur;
    event   item_ev;
    int     checks = 0;
    int     failures = 0;
    longint m_il = 0;
    longint m_vc = 0;
    bit     prev_sw = 1'b0;
    bit     finished = 1'b0;

    localparam longint MAXL = 64'sd2147483647;
    localparam longint MINL = -64'sd2147483648;

    function automatic longint sat(input longint x);
        if (x > MAXL) return MAXL;
        if (x < MINL) return MINL;
        return x;
    endfunction

    function automatic longint mulq(input longint a, input longint b);
        return sat((a * b) >>> FW);
    endfunction

    task automatic check_val(input string tag, input string name,
                             input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
        end
    endtask

    task automatic push(input string tag, input longint il, input longint vc,
                        input longint ld);
        exp_t e;
        e.il = il;
        e.vc = vc;
        e.ld = ld;
        e.tag = tag;
        sb.push_back(e);
        -> item_ev;
    endtask

    // Monitor: pops predictions and compares them with the ports.
    initial begin
        forever begin
            @(item_ev);
            while (sb.size() > 0) begin
                cur = sb.pop_front();
                check_val(cur.tag, "i_ind", longint'(i_ind), cur.il);
                check_val(cur.tag, "v_cap", longint'(v_cap), cur.vc);
                check_val("R8", "i_load", longint'(i_load), cur.ld);
            end
        end
    end

    // Driver: set the switch, sample at clock edge k after the change.
    task automatic step(input bit sw, input int k, input string tag);
        longint vrl, ild, v2, icr, vl, ic;
        bit     on;
        @(negedge clk);
        sw_in = sw;
        repeat (k - 1) @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        on = (k >= 5) ? sw : prev_sw;   // R5 latency rule
        prev_sw = sw;
        vrl = mulq(m_il, longint'(rser));
        ild = mulq(m_vc, longint'(gload));
        v2  = on ? 64'sd0 : m_vc;
        icr = on ? 64'sd0 : m_il;
        vl  = sat(longint'(vin) - vrl - v2);
        ic  = sat(icr - ild);
        m_il = sat(m_il + (vl >>> shift_l));
        m_vc = sat(m_vc + (ic >>> shift_c));
        push(tag, m_il, m_vc, ild);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        push("R1", 0, 0, 0);
        rst_n = 1'b1;
        m_il = 0;
        m_vc = 0;
        prev_sw = sw_in;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        push("R1", 0, 0, 0);
        rst_n = 1'b1;

        vin     = 32'sd6553600;   // 100.0
        rser    = 32'sd3277;      // 0.05
        gload   = 32'sd6554;      // 0.1
        shift_l = 5'd6;
        shift_c = 5'd8;

        for (int i = 0; i < 40; i++) step(1'b1, 7, "R2");
        for (int i = 0; i < 300; i++) begin
            if ((i / 2) % 2 == 0) step(1'b1, 7, "R2");
            else                  step(1'b0, 7, "R3");
        end

        // R4: long idle, integrators must hold
        repeat (20) @(negedge clk);
        push("R4", m_il, m_vc, mulq(m_vc, longint'(gload)));

        // R5: switch latency probes
        step(1'b1, 7, "R2");
        step(1'b0, 4, "R5");
        step(1'b0, 7, "R3");
        step(1'b1, 5, "R5");

        shift_l = 5'd3;
        shift_c = 5'd5;
        for (int i = 0; i < 20; i++) step(i[0], 7, "R3");

        // R7: floor shift of a tiny negative term
        do_reset();
        vin = -32'sd1;
        rser = '0;
        gload = '0;
        shift_l = 5'd4;
        shift_c = 5'd4;
        step(1'b1, 7, "R7");
        step(1'b1, 7, "R7");

        // R6: saturation both ways
        vin = 32'sh7FFF0000;
        shift_l = 5'd0;
        shift_c = 5'd0;
        for (int i = 0; i < 3; i++) step(1'b1, 7, "R6");
        vin = 32'sh80000000;
        for (int i = 0; i < 4; i++) step(1'b1, 7, "R6");
        for (int i = 0; i < 3; i++) step(1'b0, 7, "R6");

        // R1: reset in the middle of a run
        vin = 32'sd6553600;
        rser = 32'sd3277;
        gload = 32'sd6554;
        shift_l = 5'd6;
        shift_c = 5'd8;
        step(1'b0, 7, "R3");
        do_reset();
        step(1'b1, 7, "R2");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R1 actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule